// File: doc/BRIEF.md
# Clear-Then-Load Addressed Memory

This block is a small addressed register array whose storage cells can only add into what they already hold. To give ordinary overwrite behaviour, every write is split by a built-in sequencer into two bus cycles on a shared write bus. In the first cycle the bus carries the target address together with a clear marker, and the matching cell is zeroed. In the second cycle the bus carries the address and the data word with the marker removed, and the matching cell adds the data to its now-zero contents.

A client issues a write as a single-cycle request carrying an address and a data word. The sequencer captures both and holds them on the bus for the two phases. While it is working it raises a busy flag, and any request seen during that time is dropped. A one-cycle done pulse follows the load phase. Reads use their own address port and return the addressed cell one clock later. Every cell answers to one fixed address of its own. An address that no cell owns reads as zero, and a write to it changes nothing.

Top module: `zload_mem`

## Requirements
- R1: During reset and in the cycle after it ends, `rd_data`, `wr_busy` and `wr_done` are 0, and every cell reads 0 after reset.
- R2: A request (`wr_req`=1) sampled while `wr_busy`=0 is accepted. `wr_busy` is then 1 for exactly the two cycles after the accepting edge.
- R3: In the clear phase (the first busy cycle) the addressed cell is set to zero, and the data on the write bus has no effect on it.
- R4: In the load phase (the second busy cycle) the addressed cell takes the data word. Because the clear came first, a completed write leaves exactly the written word in the cell, whatever the cell held before.
- R5: `wr_done` is 1 for exactly one cycle, the cycle right after the load phase, in which `wr_busy` is already 0.
- R6: A request sampled while `wr_busy`=1 is ignored. It changes no cell and does not lengthen or restart the busy period.
- R7: `rd_data` shows the contents of the cell addressed by `rd_addr`, as they were at a clock edge, from that edge until the next one. This gives one cycle of read latency, and the read port is independent of the write port.
- R8: When a read targets the cell being written, a read address sampled at the edge that ends the clear phase returns the old value. One sampled at the edge that ends the load phase returns 0. One sampled on the next edge returns the new value.
- R9: An address that no cell owns reads as 0, and a write to it changes no cell. The sequencer still runs through busy and done as usual.
- R10: Cell i (i = 0 to 15) owns address `CELL_BASE`+i, with `CELL_BASE`=8 and 5-bit addresses. Addresses 8 to 23 are therefore valid, and 0 to 7 and 24 to 31 are not.
- R11: The address and data are captured on the accepting edge. Changes to `wr_addr` or `wr_data` during the busy cycles do not affect the stored result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Single-cycle write request |
| wr_addr | input | ADDR_W (5) | Write address |
| wr_data | input | DATA_W (16) | Write data word |
| rd_addr | input | ADDR_W (5) | Read address |
| rd_data | output | DATA_W (16) | Registered read data |
| wr_busy | output | 1 | Sequencer busy in clear or load phase |
| wr_done | output | 1 | One-cycle pulse after a write completes |

## Verification
The assertions assume that `wr_req` is a clean synchronous level that can be held high across several cycles, and that reset is applied for at least one clock before any activity. They also assume that a request may arrive on any cycle, including during busy. The stimulus drives all inputs on falling edges and holds reset for several cycles. It deliberately keeps `wr_req` high during both busy phases and releases it on the done cycle, so the drop rule and the first acceptable cycle are both exercised. Read addresses, including addresses outside the owned range, are changed freely while writes are in flight, because the assertions place no constraint on the read side.

// File: rtl/zload_pkg.sv
package zload_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_CLEAR = 2'd1,
    SEQ_LOAD  = 2'd2
  } seq_state_t;

  // Address owned by cell number idx
  function automatic int unsigned cell_addr(input int unsigned base, input int unsigned idx);
    return base + idx;
  endfunction

endpackage

// File: rtl/zload_seq.sv
module zload_seq
  import zload_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              bus_clr,
  output logic              bus_ld,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic              busy,
  output logic              done
);

  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:  if (req) state_d = SEQ_CLEAR;
      SEQ_CLEAR: state_d = SEQ_LOAD;
      SEQ_LOAD:  state_d = SEQ_IDLE;
      default:   state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SEQ_IDLE;
      bus_addr <= '0;
      bus_data <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      state_q <= state_d;
      busy    <= (state_d != SEQ_IDLE);
      done    <= (state_q == SEQ_LOAD);
      if (state_q == SEQ_IDLE && req) begin
        bus_addr <= req_addr;
        bus_data <= req_data;
      end
    end
  end

  assign bus_clr = (state_q == SEQ_CLEAR);
  assign bus_ld  = (state_q == SEQ_LOAD);

endmodule

// File: rtl/zload_cell.sv
module zload_cell #(
  parameter int              ADDR_W  = 5,
  parameter int              DATA_W  = 16,
  parameter logic [ADDR_W-1:0] MY_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_clr,
  input  logic              bus_ld,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_term
);

  logic [DATA_W-1:0] acc_q;
  logic              wsel;

  assign wsel = (bus_addr == MY_ADDR);

  // Accumulating storage: clear wins, load adds
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (wsel && bus_clr) begin
      acc_q <= '0;
    end else if (wsel && bus_ld) begin
      acc_q <= acc_q + bus_data;
    end
  end

  assign rd_term = (rd_addr == MY_ADDR) ? acc_q : '0;

endmodule

// File: rtl/zload_rdsel.sv
module zload_rdsel #(
  parameter int NUM_CELLS = 16,
  parameter int DATA_W    = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_CELLS-1:0][DATA_W-1:0]  terms,
  output logic [DATA_W-1:0]                 rd_data
);

  logic [DATA_W-1:0] merged;

  // At most one term is non-zero; OR them together
  always_comb begin
    merged = '0;
    for (int i = 0; i < NUM_CELLS; i++) begin
      merged = merged | terms[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= merged;
  end

endmodule

// File: rtl/zload_mem.sv
module zload_mem
  import zload_pkg::*;
#(
  parameter int NUM_CELLS = 16,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 5,
  parameter int CELL_BASE = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_busy,
  output logic              wr_done
);

  localparam int LAST_ADDR = CELL_BASE + NUM_CELLS - 1;

  logic              bus_clr;
  logic              bus_ld;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_data;
  logic [NUM_CELLS-1:0][DATA_W-1:0] terms;

  zload_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req      (wr_req),
    .req_addr (wr_addr),
    .req_data (wr_data),
    .bus_clr  (bus_clr),
    .bus_ld   (bus_ld),
    .bus_addr (bus_addr),
    .bus_data (bus_data),
    .busy     (wr_busy),
    .done     (wr_done)
  );

  for (genvar gi = 0; gi < NUM_CELLS; gi++) begin : g_cell
    zload_cell #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .MY_ADDR (ADDR_W'(cell_addr(CELL_BASE, gi)))
    ) u_cell (
      .clk      (clk),
      .rst      (rst),
      .bus_clr  (bus_clr),
      .bus_ld   (bus_ld),
      .bus_addr (bus_addr),
      .bus_data (bus_data),
      .rd_addr  (rd_addr),
      .rd_term  (terms[gi])
    );
  end

  zload_rdsel #(
    .NUM_CELLS (NUM_CELLS),
    .DATA_W    (DATA_W)
  ) u_rdsel (
    .clk     (clk),
    .rst     (rst),
    .terms   (terms),
    .rd_data (rd_data)
  );

  initial begin
    if (LAST_ADDR >= (1 << ADDR_W)) $error("cell addresses exceed address width");
  end

endmodule

// File: rtl/zload_mem_chk.sv
module zload_mem_chk (
  input logic clk,
  input logic rst,
  input logic wr_req,
  input logic wr_busy,
  input logic wr_done,
  input logic bus_clr,
  input logic bus_ld
);

  // R2: idle request is accepted
  a_r2_accept: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_busy) |=> wr_busy);

  // R2: busy lasts at least two cycles
  a_r2_busy_min: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_busy) |=> wr_busy);

  // R2, R6: busy never exceeds two cycles
  a_r6_busy_max: assert property (@(posedge clk) disable iff (rst)
    (wr_busy && $past(wr_busy)) |=> !wr_busy);

  // R3: clear phase is followed by load phase
  a_r3_clear_then_load: assert property (@(posedge clk) disable iff (rst)
    bus_clr |=> bus_ld);

  // R3: phases never overlap with each other or with done
  a_r3_phase_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_clr, bus_ld, wr_done}));

  // R5: done follows load
  a_r5_done_after_load: assert property (@(posedge clk) disable iff (rst)
    bus_ld |=> (wr_done && !wr_busy));

  // R5: done is a single-cycle pulse
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    wr_done |=> !wr_done);

endmodule

bind zload_mem zload_mem_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_req  (wr_req),
  .wr_busy (wr_busy),
  .wr_done (wr_done),
  .bus_clr (bus_clr),
  .bus_ld  (bus_ld)
);

// File: tb/zload_mem_test.sv
module zload_mem_test;

  localparam int AW = 5;
  localparam int DW = 16;
  localparam int BASE = 8;
  localparam int NC = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_req = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          wr_busy;
  logic          wr_done;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] mdl [32];

  always #4 clk = ~clk;  // 125 MHz

  zload_mem uut (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_busy(wr_busy), .wr_done(wr_done)
  );

  // {address, data} write vectors; read-back expectation is the data itself
  localparam logic [AW+DW-1:0] VEC [8] = '{
    {5'd8,  16'h1111}, {5'd23, 16'hFFFF}, {5'd15, 16'h00A5}, {5'd8,  16'h0F0F},
    {5'd12, 16'h8001}, {5'd20, 16'h7FFE}, {5'd15, 16'h0001}, {5'd9,  16'hC3C3}
  };

  function automatic bit owned(input int a);
    return (a >= BASE) && (a < BASE + NC);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_req = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_req = 1'b0;
    chk("R2 busy clear phase", wr_busy, 1);
    @(negedge clk);
    chk("R2 busy load phase", wr_busy, 1);
    @(negedge clk);
    chk("R5 done pulse", {wr_busy, wr_done}, 2'b01);
    @(negedge clk);
    chk("R5 done single", wr_done, 0);
    if (owned(a)) mdl[a] = d;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    for (int i = 0; i < 32; i++) mdl[i] = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {rd_data, wr_busy, wr_done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset outputs", {rd_data, wr_busy, wr_done}, 0);
    do_read(5'd8, v);  chk("R1 cell 8 zero", v, 0);
    do_read(5'd23, v); chk("R1 cell 23 zero", v, 0);

    // R4, R10: vector table of writes with read-back
    for (int k = 0; k < 8; k++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      {a, d} = VEC[k];
      do_write(a, d);
      do_read(a, v);
      chk("R4 write read-back", v, d);
    end

    // R6: requests during busy are dropped
    @(negedge clk); wr_req = 1'b1; wr_addr = 5'd10; wr_data = 16'hAAAA;
    @(negedge clk); wr_addr = 5'd11; wr_data = 16'h5555;
    chk("R6 busy first", wr_busy, 1);
    @(negedge clk);
    chk("R6 busy second", wr_busy, 1);
    @(negedge clk); wr_req = 1'b0;
    chk("R6 done, not busy", {wr_busy, wr_done}, 2'b01);
    @(negedge clk);
    chk("R6 no restart", wr_busy, 0);
    mdl[10] = 16'hAAAA;
    do_read(5'd11, v); chk("R6 dropped write left cell 11", v, mdl[11]);
    do_read(5'd10, v); chk("R6 accepted write cell 10", v, 16'hAAAA);

    // R11: inputs changing during busy have no effect
    @(negedge clk); wr_req = 1'b1; wr_addr = 5'd13; wr_data = 16'h1234;
    @(negedge clk); wr_req = 1'b0; wr_addr = 5'd14; wr_data = 16'hFFFF;
    repeat (3) @(negedge clk);
    mdl[13] = 16'h1234;
    do_read(5'd13, v); chk("R11 captured data", v, 16'h1234);
    do_read(5'd14, v); chk("R11 other cell untouched", v, mdl[14]);

    // R8 with R3: read ordering while the target is being written
    @(negedge clk); rd_addr = 5'd8; wr_req = 1'b1; wr_addr = 5'd8; wr_data = 16'h0BEE;
    @(negedge clk); wr_req = 1'b0;
    @(negedge clk);
    chk("R8 old value during clear", rd_data, mdl[8]);
    @(negedge clk);
    chk("R3 R8 zero during load", rd_data, 0);
    @(negedge clk);
    chk("R8 new value after", rd_data, 16'h0BEE);
    mdl[8] = 16'h0BEE;

    // R9: unowned addresses
    do_write(5'd3, 16'h7777);
    do_write(5'd31, 16'h4242);
    do_write(5'd24, 16'h9999);

    // R7, R9, R10: sweep every address against the model
    for (int a = 0; a < 32; a++) begin
      do_read(AW'(a), v);
      if (owned(a)) chk("R10 owned cell sweep", v, mdl[a]);
      else          chk("R9 unowned reads zero", v, 0);
    end

    // R7: back-to-back reads change each cycle
    @(negedge clk); rd_addr = 5'd23;
    @(negedge clk); chk("R7 read 23", rd_data, mdl[23]); rd_addr = 5'd12;
    @(negedge clk); chk("R7 read 12 next cycle", rd_data, mdl[12]);

    // R1: reset clears stored contents
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    do_read(5'd12, v); chk("R1 reset clears cell 12", v, 0);
    for (int i = 0; i < 32; i++) mdl[i] = '0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule